// File: doc/BRIEF.md
# Integer ALU with Status Flag Register

This block is the data path of a small integer execution stage. It takes two 32-bit operands and a 4-bit operation code. In the same cycle it produces a result, a destination write enable and the candidate negative/zero/carry/overflow word. A four-bit status register captures that candidate on the clock edge when the operation is allowed to update it. The stored carry feeds back into the add-with-carry and subtract-with-carry forms. The stored overflow bit is kept as it is by the bitwise operations.

The operations are add, subtract, reverse subtract (each with a plain form and a with-carry form), AND, OR, exclusive OR, bit clear, move and move-inverted. There are also four flag-only forms: compare, compare-negated, bit test and equality test. These set the status register even when the set-flags control is low, and they never request a destination write. For the bitwise operations, the carry flag is taken from a carry-out input that a neighbouring shifter drives.

Top module: `arith_logic_core`

## Requirements
- R1: While `rst_n` is low, `flags_q` reads 0000 whatever the other inputs are.
- R2: Codes 4 (add) and 5 (add with carry) give `op_a + op_b`, plus the stored C for code 5. Code 11 (compare negated) computes `op_a + op_b` on `result`.
- R3: Codes 2 (subtract) and 6 (subtract with carry) give `op_a - op_b`. Code 6 also subtracts NOT stored C. Code 10 (compare) computes `op_a - op_b` on `result`.
- R4: Codes 3 (reverse subtract) and 7 (reverse with carry) give `op_b - op_a`. Code 7 also subtracts NOT stored C.
- R5: The bitwise codes give: 0 `a AND b`, 1 `a XOR b`, 12 `a OR b`, 13 `b`, 14 `a AND NOT b`, 15 `NOT b`. Test code 8 shows `a AND b` and test code 9 shows `a XOR b` on `result`.
- R6: In `flags_next` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V), N equals the result MSB and Z is 1 exactly when the result is zero.
- R7: For arithmetic codes, C is the carry out of the adder, so it is 1 on subtraction when no borrow occurs. V is 1 on signed overflow. Adding -1 and 1 gives 0 with flags 0110. Adding 0x7FFFFFFF and 1 gives 0x80000000 with flags 1001.
- R8: For bitwise codes, C in `flags_next` equals `shift_c` and V equals the stored V.
- R9: Codes 8 to 11 drive `rd_we` low and load `flags_q` on the next edge even when `set_flags` is low.
- R10: For codes outside 8 to 11 with `set_flags` low, `flags_q` keeps its value across the edge.
- R11: For every code outside 8 to 11, `rd_we` is high.
- R12: When an update is allowed, `flags_q` after the edge equals `flags_next` before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the status register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation code |
| set_flags | input | 1 | Allows non-test operations to update the status register |
| shift_c | input | 1 | Carry out of the shifter, used as C by bitwise codes |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination write enable |
| flags_next | output | 4 | Candidate N,Z,C,V for the current operation |
| flags_q | output | 4 | Stored N,Z,C,V |

## Verification
The bench targets the carry sense of subtraction. A design that treated C as a borrow would flip C on every subtract, compare and reverse subtract, and would then feed the wrong value into the with-carry forms that follow. The bench also targets the signed overflow boundaries 0x7FFFFFFF+1 and 0x80000000-1. A design that got these wrong would mark overflow on ordinary sums or miss it at the sign wrap. It drives compare with `set_flags` low, which a design that gated every update on that input would fail to record. It also chains bitwise operations after an overflow, which catches a V that is cleared instead of held and a C taken from the adder instead of the shifter.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

  localparam int FLAG_W = 4;
  localparam int FLG_N  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_C  = 1;
  localparam int FLG_V  = 0;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  // Flag-only operations: never write a destination.
  function automatic logic op_is_test(alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  // Operations whose C and V come from the adder.
  function automatic logic op_is_arith(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Reverse forms swap the operands before the adder.
  function automatic logic op_swaps(alu_op_e op);
    return (op == OP_RSB) || (op == OP_RSC);
  endfunction

  // Subtracting forms invert the second adder input.
  function automatic logic op_inverts(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic cin_sel_e op_cin(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_CMP: return CIN_ONE;
      OP_ADC, OP_SBC, OP_RSC: return CIN_FLAG;
      default:                return CIN_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  output logic [W-1:0]   sum,
  output logic           c_out,
  output logic           v_out
);

  localparam int MSB = W - 1;

  logic [W-1:0] x_opnd;
  logic [W-1:0] y_raw;
  logic [W-1:0] y_opnd;
  logic         cin;
  logic [W:0]   full;

  always_comb begin
    x_opnd = op_swaps(op) ? b : a;
    y_raw  = op_swaps(op) ? a : b;
    y_opnd = op_inverts(op) ? ~y_raw : y_raw;
    case (op_cin(op))
      CIN_ZERO: cin = 1'b0;
      CIN_ONE:  cin = 1'b1;
      default:  cin = c_in;
    endcase
  end

  assign full  = {1'b0, x_opnd} + {1'b0, y_opnd} + {{W{1'b0}}, cin};
  assign sum   = full[W-1:0];
  assign c_out = full[W];
  // Signed overflow: both addends share a sign that the sum does not.
  assign v_out = (x_opnd[MSB] == y_opnd[MSB]) && (sum[MSB] != x_opnd[MSB]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/arith_logic_core.sv
module arith_logic_core
  import alu_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [3:0]        op_sel,
  input  logic              set_flags,
  input  logic              shift_c,
  output logic [W-1:0]      result,
  output logic              rd_we,
  output logic [FLAG_W-1:0] flags_next,
  output logic [FLAG_W-1:0] flags_q
);

  localparam int MSB = W - 1;

  alu_op_e      op;
  logic [W-1:0] add_sum;
  logic         add_c;
  logic         add_v;
  logic [W-1:0] log_res;
  logic         arith_w;
  logic         test_w;
  logic         flag_upd;
  logic         n_w;
  logic         z_w;
  logic         c_w;
  logic         v_w;

  assign op       = alu_op_e'(op_sel);
  assign arith_w  = op_is_arith(op);
  assign test_w   = op_is_test(op);
  assign flag_upd = set_flags | test_w;

  alu_addsub #(.W(W)) addsub_i (
    .op    (op),
    .a     (op_a),
    .b     (op_b),
    .c_in  (flags_q[FLG_C]),
    .sum   (add_sum),
    .c_out (add_c),
    .v_out (add_v)
  );

  alu_bitwise #(.W(W)) bitwise_i (
    .op  (op),
    .a   (op_a),
    .b   (op_b),
    .res (log_res)
  );

  assign result = arith_w ? add_sum : log_res;
  assign rd_we  = ~test_w;

  assign n_w = result[MSB];
  assign z_w = (result == '0);
  assign c_w = arith_w ? add_c : shift_c;
  assign v_w = arith_w ? add_v : flags_q[FLG_V];

  always_comb begin
    flags_next        = '0;
    flags_next[FLG_N] = n_w;
    flags_next[FLG_Z] = z_w;
    flags_next[FLG_C] = c_w;
    flags_next[FLG_V] = v_w;
  end

  alu_flag_reg #(.FW(FLAG_W)) flags_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (flag_upd),
    .d     (flags_next),
    .q     (flags_q)
  );

endmodule

// File: rtl/arith_logic_core_chk.sv
module arith_logic_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic         rd_we,
  input logic [3:0]   flags_next,
  input logic [3:0]   flags_q,
  input logic         flag_upd,
  input logic         arith_w
);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> $stable(flags_q)); // R10
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> (flags_q == $past(flags_next))); // R12
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[3:2] == 2'b10) |-> !rd_we); // R9
  AST_OTHER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[3:2] != 2'b10) |-> rd_we); // R11
  AST_NEG_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    flags_next[3] == result[W-1]); // R6
  AST_ZERO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    flags_next[2] == (result == '0)); // R6
  AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !arith_w) |=> (flags_q[0] == $past(flags_q[0]))); // R8

endmodule

bind arith_logic_core arith_logic_core_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_sel     (op_sel),
  .result     (result),
  .rd_we      (rd_we),
  .flags_next (flags_next),
  .flags_q    (flags_q),
  .flag_upd   (flag_upd),
  .arith_w    (arith_w)
);

// File: tb/arith_logic_core_tb_top.sv
`timescale 1ns/1ps
module arith_logic_core_tb_top;

  localparam int W = 32;
  localparam int WD_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   op_sel = 4'hD;
  logic         set_flags = 1'b0;
  logic         shift_c = 1'b0;
  logic [W-1:0] result;
  logic         rd_we;
  logic [3:0]   flags_next;
  logic [3:0]   flags_q;

  always #4 clk = ~clk;

  arith_logic_core #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .set_flags(set_flags), .shift_c(shift_c), .result(result), .rd_we(rd_we),
    .flags_next(flags_next), .flags_q(flags_q)
  );

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fn;
    logic [3:0]  fq;
    logic [23:0] rtag;
    logic [23:0] ftag;
    logic [23:0] wtag;
    logic [23:0] qtag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [3:0] model_f = 4'b0000;
  logic [31:0] rng = 32'h1234_5678;

  task automatic check(input bit ok, input logic [23:0] tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_test(input logic [3:0] op);
    return op >= 4'h8 && op <= 4'hB;
  endfunction

  // Independent reference: wide signed/unsigned arithmetic.
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic [3:0] fin,
                       output logic [31:0] r, output logic [3:0] fn,
                       output logic [23:0] rtag, output logic [23:0] ftag);
    logic [63:0] u;
    logic signed [63:0] s;
    logic [31:0] p;
    logic [31:0] q;
    logic c;
    logic v;
    logic k;
    c = sc;
    v = fin[0];
    case (op)
      4'h4, 4'h5, 4'hB: begin
        k = (op == 4'h5) ? fin[1] : 1'b0;
        u = {32'b0, a} + {32'b0, b} + {63'b0, k};
        s = $signed({{32{a[31]}}, a}) + $signed({{32{b[31]}}, b}) + $signed({63'b0, k});
        r = u[31:0];
        c = u[32];
        v = (s != $signed({{32{r[31]}}, r}));
        rtag = "R2"; ftag = "R7";
      end
      4'h2, 4'h6, 4'hA, 4'h3, 4'h7: begin
        p = (op == 4'h3 || op == 4'h7) ? b : a;
        q = (op == 4'h3 || op == 4'h7) ? a : b;
        k = (op == 4'h6 || op == 4'h7) ? ~fin[1] : 1'b0;
        u = {32'b0, p} - {32'b0, q} - {63'b0, k};
        s = $signed({{32{p[31]}}, p}) - $signed({{32{q[31]}}, q}) - $signed({63'b0, k});
        r = u[31:0];
        c = ({32'b0, p} >= ({32'b0, q} + {63'b0, k}));
        v = (s != $signed({{32{r[31]}}, r}));
        rtag = (op == 4'h3 || op == 4'h7) ? "R4" : "R3";
        ftag = "R7";
      end
      4'h0, 4'h8: begin r = a & b; rtag = "R5"; ftag = "R8"; end
      4'h1, 4'h9: begin r = a ^ b; rtag = "R5"; ftag = "R8"; end
      4'hC: begin r = a | b; rtag = "R5"; ftag = "R8"; end
      4'hD: begin r = b; rtag = "R5"; ftag = "R8"; end
      4'hE: begin r = a & ~b; rtag = "R5"; ftag = "R8"; end
      default: begin r = ~b; rtag = "R5"; ftag = "R8"; end
    endcase
    fn = {r[31], (r == 32'h0), c, v};
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input logic sc);
    exp_t e;
    bit   upd;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; set_flags = sf; shift_c = sc;
    model(op, a, b, sc, model_f, e.res, e.fn, e.rtag, e.ftag);
    upd    = sf || is_test(op);
    e.wr   = !is_test(op);
    e.wtag = is_test(op) ? "R9" : "R11";
    e.fq   = upd ? e.fn : model_f;
    e.qtag = (is_test(op) && !sf) ? "R9" : (upd ? "R12" : "R10");
    model_f = e.fq;
    exp_q.push_back(e);
  endtask

  // Monitor: comb outputs mid-cycle, stored flags just after the edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(result == e.res, e.rtag, result, e.res);
        check(rd_we == e.wr, e.wtag, {31'b0, rd_we}, {31'b0, e.wr});
        check(flags_next[3:2] == e.fn[3:2], "R6", {28'b0, flags_next}, {28'b0, e.fn});
        check(flags_next[1:0] == e.fn[1:0], e.ftag, {28'b0, flags_next}, {28'b0, e.fn});
        @(posedge clk);
        #1;
        check(flags_q == e.fq, e.qtag, {28'b0, flags_q}, {28'b0, e.fq});
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds flags at zero even with an update requested
    op_sel = 4'h4; op_a = 32'hFFFF_FFFF; op_b = 32'h1; set_flags = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flags_q == 4'b0000, "R1", {28'b0, flags_q}, 32'h0);
    op_sel = 4'hD; set_flags = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(flags_q == 4'b0000, "R1", {28'b0, flags_q}, 32'h0);

    // R7 boundary vectors
    drive(4'h4, 32'hFFFF_FFFF, 32'h1, 1, 0);      // 0, 0110
    drive(4'h4, 32'h7FFF_FFFF, 32'h1, 1, 0);      // 8000_0000, 1001
    // R3 no-borrow sets C, then R2 add with carry uses it
    drive(4'h2, 32'd5, 32'd3, 1, 0);
    drive(4'h5, 32'd1, 32'd1, 1, 0);              // 3
    // borrow clears C, then subtract with carry takes one extra
    drive(4'h2, 32'd3, 32'd5, 1, 0);
    drive(4'h6, 32'd10, 32'd3, 1, 0);             // 6
    drive(4'h2, 32'h8000_0000, 32'h1, 1, 0);      // signed overflow on subtract
    // R4 reverse forms
    drive(4'h3, 32'd3, 32'd10, 1, 0);             // 7
    drive(4'h7, 32'd3, 32'd10, 1, 0);
    drive(4'h2, 32'd0, 32'd1, 1, 0);
    drive(4'h7, 32'd3, 32'd10, 1, 0);             // 6
    // R8: bitwise keep V, take C from shifter
    drive(4'h4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
    drive(4'h0, 32'hF0F0_0000, 32'hFF00_0000, 1, 1);
    drive(4'hE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
    drive(4'hF, 32'h0, 32'h0, 1, 1);
    drive(4'hD, 32'h0, 32'h0, 1, 0);
    drive(4'hC, 32'h1200_0000, 32'h0034_0000, 1, 1);
    drive(4'h1, 32'hAAAA_5555, 32'hAAAA_5555, 1, 0);
    // R10: set_flags low keeps flags
    drive(4'h4, 32'hFFFF_FFFF, 32'h1, 0, 0);
    drive(4'h2, 32'd0, 32'd1, 0, 1);
    // R9: flag-only operations with set_flags low
    drive(4'hA, 32'd7, 32'd7, 0, 0);
    drive(4'hB, 32'hFFFF_FFFF, 32'h1, 0, 0);
    drive(4'h8, 32'hF0, 32'h0F, 0, 1);
    drive(4'h9, 32'h8000_0000, 32'h0, 1, 0);
    drive(4'hA, 32'd1, 32'd2, 0, 0);

    // mixed sweep
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      a = rng;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      b = rng;
      case (i % 7)
        1: a = 32'h7FFF_FFFF;
        2: b = 32'h8000_0000;
        3: b = a;
        4: a = 32'h0;
        default: ;
      endcase
      drive(4'(i % 16), a, b, rng[3], rng[9]);
    end

    repeat (4) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule